// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge gives a host a narrow window onto a second, internal register bus. The host sees four word-wide locations. It loads a target address and, for a write, a data word. It then writes an operation code to the command location. The bridge runs exactly one transaction on the internal request/response port and records how it ended.

The host polls the status word until the ready flag appears. A bounded poll count of 32 is enough with the default timeout. It then reads the two-bit completion code and, after a successful read, the captured data. The code tells four outcomes apart:

- the target never answered;
- the transaction succeeded;
- the request was refused because the command was not understood;
- the target answered with an error.

A target that never answers cannot hang the bridge. A cycle counter ends the transaction after a parameterised number of cycles.

Top module: `ibr_bridge`

## Requirements
- R1: After reset the status word reads 0 (ready clear, code 00), the read-data location reads 0 and no internal request is raised.
- R2: Writing 0x01 to the command location (select 3, bits [7:0]) starts an internal write; writing 0x02 starts an internal read. The request carries the address and write data held at that moment, and starting a transaction clears the ready flag and the code.
- R3: Bit 18 of the status word is the ready flag. It is set only when a transaction has finished and is never set while an internal request is raised.
- R4: Bits [17:16] of the status word hold the completion code. A response without the error flag gives 01; after such a read, the read-data location (select 2, bits [15:0]) returns the data captured from the response.
- R5: If no response arrives within TIMEOUT cycles of the start, the transaction ends with ready set and code 00. A response arriving on the TIMEOUT-th cycle of the transaction still counts as a success.
- R6: A response with the error flag set gives code 11 and leaves the read-data location unchanged.
- R7: A command code other than 0x01 or 0x02 sets ready with code 10 in the following cycle and raises no internal request.
- R8: A command written while a transaction is in flight is ignored. No second transaction is issued, and the running one keeps its address and type.
- R9: The host locations are: select 0 address (bits [15:0]), select 1 write data (bits [15:0]), select 2 read data, select 3 command on write and status on read. Read data appears on hst_rdata one cycle after the select is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_we | input | 1 | Host write strobe for the selected location |
| hst_sel | input | 2 | Host location select |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Registered readback of the selected location |
| ib_req | output | 1 | Internal request, held until response or timeout |
| ib_we | output | 1 | Internal request is a write |
| ib_addr | output | 16 | Internal address |
| ib_wdata | output | 16 | Internal write data |
| ib_rsp_valid | input | 1 | Internal response strobe |
| ib_rsp_err | input | 1 | Internal response carries an error |
| ib_rsp_rdata | input | 16 | Internal read data |

## Verification
The hardest situations to reach from the ports depend on exact timing. One is a response that lands on the very last cycle before the timeout. The other is a host command that arrives while a slow target has not yet answered. The bench's target model takes a per-transaction response delay, an error flag and a silent mode. Directed cases put the delay at TIMEOUT-1 and TIMEOUT, and issue a second command and a new address in the middle of an eight-cycle read. The target's transaction count and the stored data then show whether anything leaked through. Random transactions mix delays across and beyond the timeout with occasional errors, silences and invalid codes.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int unsigned CMD_W = 8;
  localparam logic [CMD_W-1:0] OP_WRITE = 8'h01;
  localparam logic [CMD_W-1:0] OP_READ  = 8'h02;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_WDAT = 2'd1;
  localparam logic [1:0] SEL_RDAT = 2'd2;
  localparam logic [1:0] SEL_CMD  = 2'd3;

  localparam int unsigned READY_BIT = 18;
  localparam int unsigned CODE_LSB  = 16;

  typedef enum logic [1:0] {
    CS_NORESP  = 2'b00,
    CS_OK      = 2'b01,
    CS_REQFAIL = 2'b10,
    CS_RSPERR  = 2'b11
  } cstat_t;
endpackage

// File: rtl/ibr_timer.sv
module ibr_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R5
endmodule

// File: rtl/ibr_hostregs.sv
module ibr_hostregs
  import ibr_pkg::*;
#(
  parameter int unsigned HDW = 32,
  parameter int unsigned AW  = 16,
  parameter int unsigned DW  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hst_we,
  input  logic [1:0]       hst_sel,
  input  logic [HDW-1:0]   hst_wdata,
  output logic [HDW-1:0]   hst_rdata,
  output logic             cmd_fire,
  output logic [CMD_W-1:0] cmd_code,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    wdat_q,
  input  logic [DW-1:0]    rdat_q,
  input  logic             ready,
  input  cstat_t           code
);
  logic [HDW-1:0] status_word;
  logic           unused_wbits;

  assign unused_wbits = ^hst_wdata;
  assign cmd_fire = hst_we && (hst_sel == SEL_CMD);
  assign cmd_code = hst_wdata[CMD_W-1:0];

  always_comb begin
    status_word = '0;
    status_word[READY_BIT] = ready;
    status_word[CODE_LSB +: 2] = code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else if (hst_we) begin
      if (hst_sel == SEL_ADDR) addr_q <= hst_wdata[AW-1:0];
      if (hst_sel == SEL_WDAT) wdat_q <= hst_wdata[DW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hst_rdata <= '0;
    else begin
      unique case (hst_sel)
        SEL_ADDR: hst_rdata <= HDW'(addr_q);
        SEL_WDAT: hst_rdata <= HDW'(wdat_q);
        SEL_RDAT: hst_rdata <= HDW'(rdat_q);
        default:  hst_rdata <= status_word;
      endcase
    end
  end

  AST_ADDR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (hst_we && hst_sel == SEL_ADDR) |=> addr_q == $past(hst_wdata[AW-1:0])); // R9
endmodule

// File: rtl/ibr_sequencer.sv
module ibr_sequencer
  import ibr_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned DW      = 16,
  parameter int unsigned TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_fire,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic [AW-1:0]    addr_in,
  input  logic [DW-1:0]    wdat_in,
  output logic             ib_req,
  output logic             ib_we,
  output logic [AW-1:0]    ib_addr,
  output logic [DW-1:0]    ib_wdata,
  input  logic             ib_rsp_valid,
  input  logic             ib_rsp_err,
  input  logic [DW-1:0]    ib_rsp_rdata,
  output logic             ready,
  output cstat_t           code,
  output logic [DW-1:0]    rdat_q
);
  logic busy;
  logic expired;
  logic valid_op;

  assign valid_op = (cmd_code == OP_WRITE) || (cmd_code == OP_READ);
  assign ib_req   = busy;

  ibr_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (busy),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      ready    <= 1'b0;
      code     <= CS_NORESP;
      ib_we    <= 1'b0;
      ib_addr  <= '0;
      ib_wdata <= '0;
      rdat_q   <= '0;
    end else if (busy) begin
      if (ib_rsp_valid) begin
        busy  <= 1'b0;
        ready <= 1'b1;
        code  <= ib_rsp_err ? CS_RSPERR : CS_OK;
        if (!ib_we && !ib_rsp_err) rdat_q <= ib_rsp_rdata;
      end else if (expired) begin
        busy  <= 1'b0;
        ready <= 1'b1;
        code  <= CS_NORESP;
      end
    end else if (cmd_fire) begin
      if (valid_op) begin
        busy     <= 1'b1;
        ready    <= 1'b0;
        code     <= CS_NORESP;
        ib_we    <= (cmd_code == OP_WRITE);
        ib_addr  <= addr_in;
        ib_wdata <= wdat_in;
      end else begin
        ready <= 1'b1;
        code  <= CS_REQFAIL;
      end
    end
  end

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!ib_req && cmd_fire && valid_op) |=> (ib_req && !ready && code == CS_NORESP)); // R2
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ib_req && ready)); // R3
  AST_OK_CODE: assert property (@(posedge clk) disable iff (rst)
    (ib_req && ib_rsp_valid && !ib_rsp_err) |=> (ready && code == CS_OK)); // R4
  AST_TIMEOUT_CODE: assert property (@(posedge clk) disable iff (rst)
    (ib_req && !ib_rsp_valid && expired) |=> (ready && !ib_req && code == CS_NORESP)); // R5
  AST_ERR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    (ib_req && ib_rsp_valid && ib_rsp_err) |=> (code == CS_RSPERR && $stable(rdat_q))); // R6
  AST_BAD_CMD: assert property (@(posedge clk) disable iff (rst)
    (!ib_req && cmd_fire && !valid_op) |=> (ready && !ib_req && code == CS_REQFAIL)); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (ib_req && cmd_fire) |=> ($stable(ib_addr) && $stable(ib_we))); // R8
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
  import ibr_pkg::*;
#(
  parameter int unsigned HDW     = 32,
  parameter int unsigned AW      = 16,
  parameter int unsigned DW      = 16,
  parameter int unsigned TIMEOUT = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hst_we,
  input  logic [1:0]     hst_sel,
  input  logic [HDW-1:0] hst_wdata,
  output logic [HDW-1:0] hst_rdata,
  output logic           ib_req,
  output logic           ib_we,
  output logic [AW-1:0]  ib_addr,
  output logic [DW-1:0]  ib_wdata,
  input  logic           ib_rsp_valid,
  input  logic           ib_rsp_err,
  input  logic [DW-1:0]  ib_rsp_rdata
);
  logic             cmd_fire;
  logic [CMD_W-1:0] cmd_code;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdat_q;
  logic [DW-1:0]    rdat_q;
  logic             ready;
  cstat_t           code;

  ibr_hostregs #(.HDW(HDW), .AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .hst_we    (hst_we),
    .hst_sel   (hst_sel),
    .hst_wdata (hst_wdata),
    .hst_rdata (hst_rdata),
    .cmd_fire  (cmd_fire),
    .cmd_code  (cmd_code),
    .addr_q    (addr_q),
    .wdat_q    (wdat_q),
    .rdat_q    (rdat_q),
    .ready     (ready),
    .code      (code)
  );

  ibr_sequencer #(.AW(AW), .DW(DW), .TIMEOUT(TIMEOUT)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .cmd_fire     (cmd_fire),
    .cmd_code     (cmd_code),
    .addr_in      (addr_q),
    .wdat_in      (wdat_q),
    .ib_req       (ib_req),
    .ib_we        (ib_we),
    .ib_addr      (ib_addr),
    .ib_wdata     (ib_wdata),
    .ib_rsp_valid (ib_rsp_valid),
    .ib_rsp_err   (ib_rsp_err),
    .ib_rsp_rdata (ib_rsp_rdata),
    .ready        (ready),
    .code         (code),
    .rdat_q       (rdat_q)
  );
endmodule

// File: tb/ibr_bridge_test.sv
module ibr_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int T = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_we = 1'b0;
  logic [1:0]  hst_sel = 2'd0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        ib_req, ib_we;
  logic [15:0] ib_addr, ib_wdata;
  logic        ib_rsp_valid = 1'b0;
  logic        ib_rsp_err = 1'b0;
  logic [15:0] ib_rsp_rdata = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int tgt_delay = 0;
  bit tgt_err = 0;
  bit tgt_silent = 0;
  int txn_count = 0;
  bit req_seen = 0;
  logic [15:0] tgt_mem [16];
  logic [15:0] exp_mem [16];
  logic [15:0] exp_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ibr_bridge #(.TIMEOUT(T)) uut (
    .clk(clk), .rst(rst), .hst_we(hst_we), .hst_sel(hst_sel),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .ib_req(ib_req),
    .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
    .ib_rsp_valid(ib_rsp_valid), .ib_rsp_err(ib_rsp_err),
    .ib_rsp_rdata(ib_rsp_rdata)
  );

  always @(posedge clk) if (ib_req) req_seen <= 1'b1;

  // Target model: answers after tgt_delay cycles unless silent
  initial begin
    for (int i = 0; i < 16; i++) tgt_mem[i] = 16'(i * 16'h1357 + 16'h0a0a);
    forever begin
      @(negedge clk);
      if (ib_req) begin
        txn_count++;
        if (!tgt_silent) begin
          repeat (tgt_delay) @(negedge clk);
          if (ib_req) begin
            ib_rsp_valid = 1'b1;
            ib_rsp_err   = tgt_err;
            ib_rsp_rdata = tgt_err ? 16'hdead : tgt_mem[ib_addr[3:0]];
            if (ib_we && !tgt_err) tgt_mem[ib_addr[3:0]] = ib_wdata;
            @(negedge clk);
            ib_rsp_valid = 1'b0;
            ib_rsp_err   = 1'b0;
          end
        end
        while (ib_req) @(negedge clk);
      end
    end
  end

  function automatic logic [1:0] exp_code(bit silent, bit err, int delay);
    if (silent || delay > T - 1) return 2'b00;
    if (err) return 2'b11;
    return 2'b01;
  endfunction

  function automatic logic [31:0] status_word(logic [1:0] c);
    return (32'd1 << 18) | (32'(c) << 16);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    hst_we = 1'b1; hst_sel = sel; hst_wdata = d;
    @(negedge clk);
    hst_we = 1'b0;
  endtask

  task automatic host_read(logic [1:0] sel, output logic [31:0] v);
    hst_sel = sel;
    @(negedge clk);
    v = hst_rdata;
  endtask

  task automatic poll(output logic [31:0] st);
    for (int k = 0; k < 32; k++) begin
      host_read(2'd3, st);
      if (st[18]) break;
    end
  endtask

  // One transaction with a chosen target behaviour; checks status and read data
  task automatic run_txn(string req, logic [7:0] op, logic [15:0] a, logic [15:0] d,
                         int delay, bit err, bit silent);
    logic [31:0] st, rv;
    logic [1:0] ec;
    tgt_delay = delay; tgt_err = err; tgt_silent = silent;
    host_write(2'd0, {16'h0, a});
    host_write(2'd1, {16'h0, d});
    host_write(2'd3, {24'h0, op});
    poll(st);
    if (op == 8'h01 || op == 8'h02) ec = exp_code(silent, err, delay);
    else ec = 2'b10;
    check(req, st, status_word(ec));
    if (ec == 2'b01 && op == 8'h01) exp_mem[a[3:0]] = d;
    if (ec == 2'b01 && op == 8'h02) exp_rd = exp_mem[a[3:0]];
    host_read(2'd2, rv);
    check(req, rv, {16'h0, exp_rd});
  endtask

  initial begin
    logic [31:0] v;
    int n0;
    void'($urandom(32'h1b2c));
    for (int i = 0; i < 16; i++) exp_mem[i] = 16'(i * 16'h1357 + 16'h0a0a);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    host_read(2'd3, v); check("R1 status", v, 32'h0);
    host_read(2'd2, v); check("R1 rdata", v, 32'h0);
    check("R1 req", {31'h0, ib_req}, 32'h0);

    // R9 address and write-data readback
    host_write(2'd0, 32'hffff_abcd);
    host_read(2'd0, v); check("R9 addr", v, 32'h0000_abcd);
    host_write(2'd1, 32'h1234_5678);
    host_read(2'd1, v); check("R9 wdata", v, 32'h0000_5678);

    // R2 R4 write then read back
    run_txn("R2 write", 8'h01, 16'h0003, 16'hbeef, 2, 0, 0);
    run_txn("R4 read", 8'h02, 16'h0003, 16'h0000, 0, 0, 0);
    check("R4 data", {16'h0, exp_rd}, 32'h0000_beef);

    // R2 request fields observed on the port
    tgt_delay = 4; tgt_err = 0; tgt_silent = 0;
    host_write(2'd0, 32'h0000_0105);
    host_write(2'd1, 32'h0000_7777);
    host_write(2'd3, 32'h0000_0001);
    check("R2 req fields", {ib_req, ib_we, ib_addr, 14'h0}, {1'b1, 1'b1, 16'h0105, 14'h0});
    host_read(2'd3, v); check("R2 ready cleared", v, 32'h0);
    poll(v); check("R3 ready", v, status_word(2'b01));
    exp_mem[5] = 16'h7777;

    // R5 timeout boundary
    run_txn("R5 last-cycle ok", 8'h02, 16'h0005, 16'h0, T - 1, 0, 0);
    run_txn("R5 late", 8'h02, 16'h0006, 16'h0, T, 0, 0);
    run_txn("R5 silent", 8'h01, 16'h0007, 16'h1111, 0, 0, 1);

    // R6 error response keeps read data
    run_txn("R6 err read", 8'h02, 16'h0008, 16'h0, 1, 1, 0);
    run_txn("R6 err write", 8'h01, 16'h0008, 16'h4242, 0, 1, 0);

    // R7 invalid code, no request
    req_seen = 0;
    run_txn("R7 bad code", 8'h00, 16'h0009, 16'h0, 0, 0, 0);
    check("R7 no req", {31'h0, req_seen}, 32'h0);
    run_txn("R7 bad code 3", 8'h03, 16'h0009, 16'h0, 0, 0, 0);

    // R8 command during an in-flight read is ignored
    tgt_delay = 8; tgt_err = 0; tgt_silent = 0;
    n0 = txn_count;
    host_write(2'd0, 32'h0000_0002);
    host_write(2'd3, 32'h0000_0002);
    host_write(2'd0, 32'h0000_000b);
    host_write(2'd1, 32'h0000_9999);
    host_write(2'd3, 32'h0000_0001);
    poll(v); check("R8 status", v, status_word(2'b01));
    exp_rd = exp_mem[2];
    host_read(2'd2, v); check("R8 read data", v, {16'h0, exp_rd});
    check("R8 one txn", 32'(txn_count - n0), 32'd1);
    run_txn("R8 untouched", 8'h02, 16'h000b, 16'h0, 0, 0, 0);

    // Random mix
    for (int i = 0; i < 40; i++) begin
      logic [7:0] op;
      int r;
      r = $urandom_range(0, 15);
      op = (r == 0) ? 8'($urandom_range(3, 255)) : ((r < 8) ? 8'h01 : 8'h02);
      run_txn("R4 random", op, 16'($urandom), 16'($urandom),
              $urandom_range(0, T + 2), ($urandom_range(0, 7) == 0),
              ($urandom_range(0, 15) == 0));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule